// File: doc/BRIEF.md
# Linked-Descriptor Block Mover

This block moves data between system memory and a peripheral data FIFO by walking a chain of descriptors that software places in memory. Every descriptor spans four 32-bit words: a flags word with the byte count, a format bit and an end-of-chain bit, then the buffer address, then the address of the next descriptor, then a spare word that the engine never reads. Software writes the address of the first descriptor and picks a direction. It then sets the start bit. The engine fetches descriptors and moves whole 32-bit words one at a time until it meets a descriptor marked as the last one.

When the chain finishes, or when something goes wrong, the engine records a 4-bit event code, clears its run bit and sets a sticky interrupt status. The interrupt output is that status gated by an enable bit. The control/status port is a simple word-indexed register port with a same-cycle write and a combinational read. Memory is reached through a single-word request/acknowledge port that carries an error flag. The peripheral side has a valid/ready pair in each direction, plus an end-of-data signal from the source.

Top module: `dmac_chain`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and `mem_req`, `tx_valid` and `rx_ready` are all low.
- R2: Register index 0 is global control. Writing bit 8 resets every register and aborts the engine, and bit 0 then reads 0. Writing bit 0 enables the engine and reads back as 1. A start written while bit 0 is 0 is ignored, and run stays 0.
- R3: A descriptor is read as words at pointer+0 (flags: byte count in bits 15:0, format in bit 30, last in bit 31), pointer+4 (buffer) and pointer+8 (next). The word at pointer+12 is never read. Register index 3 holds the pointer to the first descriptor.
- R4: With channel control (index 4) bit 22 clear, each descriptor reads ceil(count/4) words from consecutive buffer addresses and presents them on `tx_data` in order. A count of 0 moves no data.
- R5: With bit 22 set, the words accepted on `rx_data` are written to consecutive buffer words, ceil(count/4) per descriptor.
- R6: After a descriptor with the last bit clear, the next one is fetched from its next address. After one with the last bit set, the event code (channel control bits 3:0) becomes 0xF, run clears and the status bit is set.
- R7: An error response on a descriptor word fetch, or a fetched flags word with the format bit clear, ends the chain with event code 3, and no further data moves.
- R8: An error response on a buffer read or write ends the chain with event code 4.
- R9: In the peripheral-to-memory direction, `pf_end` while the engine waits for a word that is still owed ends the chain with event code 5.
- R10: `irq` equals status (index 2, bit 0) AND enable (index 1, bit 0). Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R11: A memory request holds its address, direction and data until acknowledged, and a `tx_valid` word holds until `tx_ready`.
- R12: Writing channel control with bit 7 set while enabled and idle starts the engine. Bit 7 then reads 1 until the chain ends, and the event code reads 0 while the chain runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Completion carried an error |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Word offered to the peripheral |
| tx_data | output | 32 | Word to the peripheral |
| tx_ready | input | 1 | Peripheral takes the word |
| rx_valid | input | 1 | Peripheral offers a word |
| rx_data | input | 32 | Word from the peripheral |
| rx_ready | output | 1 | Engine takes the word |
| pf_end | input | 1 | Peripheral has no more data |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples it, so the bench reads the register back on the next falling edge. A memory acknowledgement or FIFO handshake seen at one edge moves the engine to its next state at that same edge. The final event code, the cleared run bit and `irq` therefore appear one cycle after the last handshake. Because data-path latency varies with the stall patterns, the bench does not count cycles. The scoreboard instead pops its expected word at the falling edge before each handshake edge. Final status is read only after polling shows run clear.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int unsigned CSR_GCTL = 0;
  localparam int unsigned CSR_IEN  = 1;
  localparam int unsigned CSR_IST  = 2;
  localparam int unsigned CSR_DPTR = 3;
  localparam int unsigned CSR_CHAN = 4;

  localparam int unsigned GC_EN   = 0;
  localparam int unsigned GC_SRST = 8;
  localparam int unsigned CH_RUN  = 7;
  localparam int unsigned CH_DIR  = 22;
  localparam int unsigned FL_FMT  = 30;
  localparam int unsigned FL_LAST = 31;

  typedef enum logic [3:0] {
    EV_NONE  = 4'h0,
    EV_UNDER = 4'h1,
    EV_OVER  = 4'h2,
    EV_DESC  = 4'h3,
    EV_DATA  = 4'h4,
    EV_EARLY = 4'h5,
    EV_OK    = 4'hF
  } ev_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_MRD, S_TXPUSH, S_RXWAIT, S_MWR, S_NEXT
  } walk_st_e;

  // number of 32-bit words covering a byte count
  function automatic logic [14:0] words_of(input logic [15:0] bytes);
    logic [16:0] t;
    t = {1'b0, bytes} + 17'd3;
    return t[16:2];
  endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CSR_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              done_ev,
  input  logic [3:0]        done_code,
  output logic              start,
  output logic              sw_rst,
  output logic              dir,
  output logic [AW-1:0]     dptr,
  output logic              run,
  output logic              en,
  output logic              ie,
  output logic              ist,
  output logic [3:0]        evt,
  output logic              irq
);

  logic unused_wbits;
  assign unused_wbits = &{1'b0, csr_wdata};

  logic wr_gc, wr_ie, wr_is, wr_dp, wr_ch;
  assign wr_gc = csr_we && (csr_addr == CSR_AW'(CSR_GCTL));
  assign wr_ie = csr_we && (csr_addr == CSR_AW'(CSR_IEN));
  assign wr_is = csr_we && (csr_addr == CSR_AW'(CSR_IST));
  assign wr_dp = csr_we && (csr_addr == CSR_AW'(CSR_DPTR));
  assign wr_ch = csr_we && (csr_addr == CSR_AW'(CSR_CHAN));

  assign sw_rst = wr_gc && csr_wdata[GC_SRST];
  assign start  = wr_ch && csr_wdata[CH_RUN] && en && !run && !sw_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; ie <= 1'b0; ist <= 1'b0; dir <= 1'b0;
      run <= 1'b0; evt <= EV_NONE; dptr <= '0;
    end else if (sw_rst) begin
      en <= 1'b0; ie <= 1'b0; ist <= 1'b0; dir <= 1'b0;
      run <= 1'b0; evt <= EV_NONE; dptr <= '0;
    end else begin
      if (wr_gc) en <= csr_wdata[GC_EN];
      if (wr_ie) ie <= csr_wdata[0];
      if (wr_is && csr_wdata[0]) ist <= 1'b0;
      if (wr_dp && !run) dptr <= csr_wdata[AW-1:0];
      if (wr_ch && !run) dir <= csr_wdata[CH_DIR];
      if (start) begin
        run <= 1'b1;
        evt <= EV_NONE;
      end
      if (done_ev) begin
        run <= 1'b0;
        evt <= done_code;
        ist <= 1'b1;
      end
    end
  end

  assign irq = ist && ie;

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      CSR_AW'(CSR_GCTL): csr_rdata[GC_EN] = en;
      CSR_AW'(CSR_IEN):  csr_rdata[0] = ie;
      CSR_AW'(CSR_IST):  csr_rdata[0] = ist;
      CSR_AW'(CSR_DPTR): csr_rdata = 32'(dptr);
      CSR_AW'(CSR_CHAN): begin
        csr_rdata[3:0]    = evt;
        csr_rdata[CH_RUN] = run;
        csr_rdata[CH_DIR] = dir;
      end
      default: csr_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dmac_walk.sv
module dmac_walk
  import dmac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic          dir,
  input  logic [AW-1:0] dptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [31:0]   tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [31:0]   rx_data,
  output logic          rx_ready,
  input  logic          pf_end,
  output logic          fetching,
  output logic          fetch_err_ev,
  output logic          data_err_ev,
  output logic          early_end_ev,
  output logic          chain_end_ev,
  output logic          done_ev,
  output logic [3:0]    done_code
);

  walk_st_e      st;
  logic [AW-1:0] dsc, bufp, branch, cur;
  logic [1:0]    fidx;
  logic [15:0]   cnt;
  logic          fmt, last;
  logic [14:0]   left;
  logic [31:0]   hold;
  logic          unused_rd;

  assign unused_rd = &{1'b0, mem_rdata[29:16]};

  assign fetching     = (st == S_FETCH);
  assign fetch_err_ev = (fetching && mem_ack && mem_err) || (st == S_CHECK && !fmt);
  assign data_err_ev  = (st == S_MRD || st == S_MWR) && mem_ack && mem_err;
  assign early_end_ev = (st == S_RXWAIT) && !rx_valid && pf_end;
  assign chain_end_ev = (st == S_NEXT) && last;
  assign done_ev      = !abort && (fetch_err_ev || data_err_ev || early_end_ev || chain_end_ev);

  always_comb begin
    if (fetch_err_ev)      done_code = EV_DESC;
    else if (data_err_ev)  done_code = EV_DATA;
    else if (early_end_ev) done_code = EV_EARLY;
    else                   done_code = EV_OK;
  end

  assign mem_req   = (st == S_FETCH) || (st == S_MRD) || (st == S_MWR);
  assign mem_we    = (st == S_MWR);
  assign mem_addr  = fetching ? dsc + AW'({fidx, 2'b00}) : cur;
  assign mem_wdata = hold;
  assign tx_valid  = (st == S_TXPUSH);
  assign tx_data   = hold;
  assign rx_ready  = (st == S_RXWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dsc <= '0; bufp <= '0; branch <= '0; cur <= '0;
      fidx <= '0; cnt <= '0; fmt <= 1'b0; last <= 1'b0; left <= '0; hold <= '0;
    end else if (abort) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dsc <= dptr; fidx <= '0; st <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) st <= S_IDLE;
          else begin
            case (fidx)
              2'd0: begin
                cnt <= mem_rdata[15:0]; fmt <= mem_rdata[FL_FMT]; last <= mem_rdata[FL_LAST];
              end
              2'd1:    bufp   <= mem_rdata[AW-1:0];
              default: branch <= mem_rdata[AW-1:0];
            endcase
            if (fidx == 2'd2) st <= S_CHECK;
            else fidx <= fidx + 2'd1;
          end
        end
        S_CHECK: begin
          if (!fmt) st <= S_IDLE;
          else begin
            left <= words_of(cnt);
            cur  <= bufp;
            if (words_of(cnt) == '0) st <= S_NEXT;
            else st <= dir ? S_RXWAIT : S_MRD;
          end
        end
        S_MRD: if (mem_ack) begin
          if (mem_err) st <= S_IDLE;
          else begin hold <= mem_rdata; st <= S_TXPUSH; end
        end
        S_TXPUSH: if (tx_ready) begin
          cur <= cur + AW'(4); left <= left - 15'd1;
          st <= (left == 15'd1) ? S_NEXT : S_MRD;
        end
        S_RXWAIT: begin
          if (rx_valid) begin hold <= rx_data; st <= S_MWR; end
          else if (pf_end) st <= S_IDLE;
        end
        S_MWR: if (mem_ack) begin
          if (mem_err) st <= S_IDLE;
          else begin
            cur <= cur + AW'(4); left <= left - 15'd1;
            st <= (left == 15'd1) ? S_NEXT : S_RXWAIT;
          end
        end
        S_NEXT: begin
          if (last) st <= S_IDLE;
          else begin dsc <= branch; fidx <= '0; st <= S_FETCH; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dmac_chain.sv
module dmac_chain
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CSR_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [31:0]       tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [31:0]       rx_data,
  output logic              rx_ready,
  input  logic              pf_end,
  output logic              irq
);

  logic          start, sw_rst, dir, run, en, ie, ist;
  logic [AW-1:0] dptr;
  logic [3:0]    evt, done_code;
  logic          done_ev, fetching;
  logic          fetch_err_ev, data_err_ev, early_end_ev, chain_end_ev;

  dmac_regs #(.AW(AW), .CSR_AW(CSR_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .done_ev(done_ev),
    .done_code(done_code), .start(start), .sw_rst(sw_rst), .dir(dir),
    .dptr(dptr), .run(run), .en(en), .ie(ie), .ist(ist), .evt(evt), .irq(irq)
  );

  dmac_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .abort(sw_rst), .start(start), .dir(dir),
    .dptr(dptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .pf_end(pf_end), .fetching(fetching),
    .fetch_err_ev(fetch_err_ev), .data_err_ev(data_err_ev),
    .early_end_ev(early_end_ev), .chain_end_ev(chain_end_ev),
    .done_ev(done_ev), .done_code(done_code)
  );

endmodule

// File: rtl/dmac_chain_chk.sv
module dmac_chain_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          mem_err,
  input logic          fetching,
  input logic          tx_valid,
  input logic [31:0]   tx_data,
  input logic          tx_ready,
  input logic          rx_ready,
  input logic          done_ev,
  input logic          chain_end_ev,
  input logic          run,
  input logic          ie,
  input logic          irq,
  input logic [3:0]    evt
);

  // R11: request fields held until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !sw_rst) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11: offered word held until taken
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !sw_rst) |=> (tx_valid && $stable(tx_data)));

  // R7: fetch error response leads to code 3
  a_r7_fetch_err: assert property (@(posedge clk) disable iff (!rst_n)
    (fetching && mem_ack && mem_err && !sw_rst) |=> (evt == 4'h3 && !run));

  // R6: end of chain leads to success code and stopped run bit
  a_r6_chain_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_end_ev && !sw_rst) |=> (evt == 4'hF && !run));

  // R10: finishing with the enable set raises the interrupt
  a_r10_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && ie && !sw_rst) |=> irq);

  // R4: directions never active together
  a_r4_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

endmodule

bind dmac_chain dmac_chain_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err), .fetching(fetching),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .rx_ready(rx_ready),
  .done_ev(done_ev), .chain_end_ev(chain_end_ev), .run(run), .ie(ie), .irq(irq),
  .evt(evt)
);

// File: tb/dmac_chain_bench.sv
`timescale 1ns/1ps
module dmac_chain_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid;
  logic [31:0] tx_data;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_ready;
  logic        pf_end = 1'b0;
  logic        irq;

  always #10 clk = ~clk;

  dmac_chain u_dmac_chain (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .pf_end(pf_end), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] exp_tx[$];
  logic [63:0] exp_wr[$];
  logic [31:0] rx_src[$];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  bit          rsv_hit = 0;
  bit          tx_stall = 0;
  bit          rx_end_req = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // memory model and write scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0; mem_err = 1'b0;
      end else if (mem_req) begin
        mem_ack = 1'b1;
        mem_err = (mem_addr == err_addr);
        if (!mem_we) begin
          mem_rdata = mem[mem_addr[11:2]];
          if (mem_addr < 32'h400 && mem_addr[3:0] == 4'hC) rsv_hit = 1;
        end else if (!mem_err) begin
          mem[mem_addr[11:2]] = mem_wdata;
          if (exp_wr.size() == 0)
            chk(0, "R5 unexpected write", {mem_addr, mem_wdata}, 64'h0);
          else begin
            logic [63:0] e;
            e = exp_wr.pop_front();
            chk({mem_addr, mem_wdata} == e, "R5 write", {mem_addr, mem_wdata}, e);
          end
        end
      end
    end
  end

  // peripheral sink with scoreboard
  initial begin
    forever begin
      @(negedge clk);
      tx_ready = !tx_stall;
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0)
          chk(0, "R4 unexpected tx word", {32'h0, tx_data}, 64'h0);
        else begin
          logic [31:0] e;
          e = exp_tx.pop_front();
          chk(tx_data == e, "R4 tx word", {32'h0, tx_data}, {32'h0, e});
        end
      end
    end
  end

  // peripheral source
  initial begin
    bit take;
    take = 0;
    forever begin
      @(negedge clk);
      if (take) void'(rx_src.pop_front());
      rx_valid = (rx_src.size() != 0);
      rx_data  = rx_valid ? rx_src[0] : 32'h0;
      pf_end   = !rx_valid && rx_end_req;
      take = rx_valid && rx_ready;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = 3'(a); csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = 3'(a);
    #1 d = csr_rdata;
  endtask

  task automatic put_desc(input int at, input logic [31:0] fl, input logic [31:0] bp, input logic [31:0] nx);
    mem[at/4] = fl; mem[at/4+1] = bp; mem[at/4+2] = nx; mem[at/4+3] = 32'hDEAD_BEEF;
  endtask

  task automatic run_chain(input int dp, input bit d, output logic [3:0] code);
    logic [31:0] v;
    wr(2, 32'h1);
    wr(3, dp);
    wr(4, (32'(d) << 22) | 32'h80);
    for (int i = 0; i < 3000; i++) begin
      rd(4, v);
      if (!v[7]) break;
    end
    code = v[3:0];
  endtask

  initial begin
    logic [31:0] v;
    logic [3:0]  code;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h1000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk(v == 0, "R1 register after reset", {32'h0, v}, 64'h0);
    end
    chk(!irq && !mem_req && !tx_valid && !rx_ready, "R1 outputs idle",
        {60'h0, irq, mem_req, tx_valid, rx_ready}, 64'h0);

    // R2 start ignored while disabled, enable, soft reset
    wr(4, 32'h80);
    rd(4, v);
    chk(v[7] == 0, "R2 start while disabled", {32'h0, v}, 64'h0);
    wr(1, 32'h1);
    wr(0, 32'h1);
    rd(0, v);
    chk(v == 1, "R2 enable readback", {32'h0, v}, 64'h1);
    wr(0, 32'h100);
    rd(0, v);
    chk(v == 0, "R2 soft reset clears enable", {32'h0, v}, 64'h0);
    rd(1, v);
    chk(v == 0, "R2 soft reset clears irq enable", {32'h0, v}, 64'h0);
    wr(0, 32'h1);
    rd(0, v);
    chk(v == 1, "R2 enable after soft reset", {32'h0, v}, 64'h1);
    wr(1, 32'h1);

    // R3 R4 R6 R12 two-descriptor chain to peripheral, stalled first
    put_desc(32'h100, 32'h4000_0008, 32'h400, 32'h200);
    put_desc(32'h200, 32'hC000_0005, 32'h500, 32'h0);
    exp_tx.push_back(mem[32'h100]); exp_tx.push_back(mem[32'h101]);
    exp_tx.push_back(mem[32'h140]); exp_tx.push_back(mem[32'h141]);
    tx_stall = 1;
    wr(3, 32'h100);
    wr(4, 32'h80);
    repeat (12) @(negedge clk);
    rd(4, v);
    chk(v[7] == 1 && v[3:0] == 0, "R12 run set and code 0 while busy", {32'h0, v}, 64'h80);
    chk(tx_valid && tx_data == mem[32'h100], "R11 word held under stall", {32'h0, tx_data}, {32'h0, mem[32'h100]});
    tx_stall = 0;
    for (int i = 0; i < 200; i++) begin rd(4, v); if (!v[7]) break; end
    chk(v[3:0] == 4'hF, "R6 success code", {60'h0, v[3:0]}, 64'hF);
    chk(exp_tx.size() == 0, "R4 all words delivered", exp_tx.size(), 0);
    chk(!rsv_hit, "R3 spare word never read", {63'h0, rsv_hit}, 0);
    chk(irq == 1, "R10 irq after chain", {63'h0, irq}, 1);

    // R10 clear semantics
    wr(2, 32'h0);
    chk(irq == 1, "R10 write 0 keeps status", {63'h0, irq}, 1);
    wr(2, 32'h1);
    chk(irq == 0, "R10 write 1 clears status", {63'h0, irq}, 0);
    wr(1, 32'h0);
    put_desc(32'h300, 32'hC000_0000, 32'h600, 32'h0);
    run_chain(32'h300, 0, code);
    rd(2, v);
    chk(irq == 0 && v == 1, "R10 status set but irq gated", {31'h0, irq, v}, 64'h1);
    wr(1, 32'h1);
    chk(irq == 1, "R10 irq follows enable", {63'h0, irq}, 1);

    // R4 zero count moves nothing, count 1 moves one word
    chk(code == 4'hF, "R4 zero count succeeds", code, 64'hF);
    put_desc(32'h300, 32'hC000_0001, 32'h600, 32'h0);
    exp_tx.push_back(mem[32'h180]);
    run_chain(32'h300, 0, code);
    chk(code == 4'hF && exp_tx.size() == 0, "R4 one byte moves one word", {code, 32'(exp_tx.size())}, 64'hF_0000_0000);

    // R5 peripheral to memory
    put_desc(32'h300, 32'hC000_000C, 32'h700, 32'h0);
    for (int i = 0; i < 3; i++) begin
      rx_src.push_back(32'hA500_0000 + i);
      exp_wr.push_back({32'h700 + 32'(4*i), 32'hA500_0000 + i});
    end
    run_chain(32'h300, 1, code);
    chk(code == 4'hF, "R5 code", code, 64'hF);
    chk(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);
    chk(mem[32'h1C2] == 32'hA500_0002, "R5 last word stored", mem[32'h1C2], 64'hA500_0002);

    // R7 format bit clear
    put_desc(32'h300, 32'h8000_0004, 32'h600, 32'h0);
    run_chain(32'h300, 0, code);
    chk(code == 4'h3, "R7 format clear", code, 64'h3);
    // R7 fetch error response
    put_desc(32'h300, 32'hC000_0004, 32'h600, 32'h0);
    err_addr = 32'h304;
    run_chain(32'h300, 0, code);
    chk(code == 4'h3, "R7 fetch error", code, 64'h3);
    chk(exp_tx.size() == 0, "R7 no data moved", exp_tx.size(), 0);

    // R8 data read error on second word
    put_desc(32'h300, 32'hC000_0008, 32'h600, 32'h0);
    err_addr = 32'h604;
    exp_tx.push_back(mem[32'h180]);
    run_chain(32'h300, 0, code);
    chk(code == 4'h4, "R8 data error", code, 64'h4);
    chk(exp_tx.size() == 0, "R8 first word delivered", exp_tx.size(), 0);
    err_addr = 32'hFFFF_FFFF;

    // R9 early end
    put_desc(32'h300, 32'hC000_0010, 32'h780, 32'h0);
    rx_src.push_back(32'h5A00_0001); rx_src.push_back(32'h5A00_0002);
    exp_wr.push_back({32'h780, 32'h5A00_0001});
    exp_wr.push_back({32'h784, 32'h5A00_0002});
    rx_end_req = 1;
    run_chain(32'h300, 1, code);
    rx_end_req = 0;
    chk(code == 4'h5, "R9 early end", code, 64'h5);
    chk(exp_wr.size() == 0, "R9 received words stored", exp_wr.size(), 0);

    finish_run();
  end

endmodule